// File: doc/BRIEF.md
# Indexed Configuration Register Window

This block holds a 256-entry bank of byte-wide configuration registers that a host reaches through a two-byte I/O window. The host first writes an entry number to the low byte of the window, which loads an internal pointer. It then reads or writes the high byte to reach that entry. A read at either byte returns the entry the pointer selects. The pointer value itself never comes back on the read path.

Data writes pass through a fixed policy before they land. Most entries are locked, and writes to them are dropped without notice. Two entries are keyed: each accepts one byte value only and silently discards every other value. The remaining entries accept any byte.

The whole window answers only while an external enable input is high. While the enable is low, writes have no effect and reads return the floating-bus value 0xFF.

Top module: `cfg_window_port`

## Requirements
- R1: After reset the pointer is 0x00 and the read data output is 0xFF. Entries 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other entry holds 0x00.
- R2: With the enable high, a write with bus_addr = 0 loads bus_wdata into the pointer. A read strobe then places the entry at the pointer on bus_rdata one clock after the strobe edge. bus_rdata keeps that value until the next read strobe.
- R3: With the enable high, a write with bus_addr = 1 to an open entry stores any byte. The open entries are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R4: Data writes to locked entries leave them unchanged. The locked entries are 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB and 0xFD–0xFF.
- R5: A data write to entry 0xE7 is stored only when the byte is 0xFE. Any other byte is discarded.
- R6: A data write to entry 0xE8 is stored only when the byte is 0xBE. Any other byte is discarded.
- R7: While win_en is low, writes at either offset change neither the pointer nor any entry, and a read strobe places 0xFF on bus_rdata.
- R8: A read at bus_addr = 0 returns the selected entry, never the pointer value.
- R9: A single write strobe updates at most one storage location (the pointer or one entry) per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_en | input | 1 | Window decode enable |
| bus_addr | input | 1 | Window offset: 0 = pointer, 1 = data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |

## Verification
The hardest cases to reach are the sparse lock map and the two keyed entries. Their effect shows only when an entry is later pointed at and read back, so one wrong range boundary would stay hidden under a few directed writes. The stimulus sweeps all 256 pointer values. It writes a probe byte to each entry, reads it back and compares against a model built from the lock lists. It then drives both right and wrong key bytes at the two keyed entries, and repeats writes with the enable low to show that nothing moves.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        POL_LOCK  = 2'd0,
        POL_OPEN  = 2'd1,
        POL_KEYED = 2'd2
    } wr_policy_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic              hi;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    localparam logic [7:0] KEY_A_IDX = 8'hE7;
    localparam logic [7:0] KEY_A_VAL = 8'hFE;
    localparam logic [7:0] KEY_B_IDX = 8'hE8;
    localparam logic [7:0] KEY_B_VAL = 8'hBE;
    localparam logic [7:0] FLOAT_VAL = 8'hFF;

    function automatic wr_policy_e policy_of(input logic [7:0] idx);
        wr_policy_e p;
        p = POL_OPEN;
        if (idx <= 8'hDF)                       p = POL_LOCK;
        else if (idx == 8'hE4 || idx == 8'hE5)  p = POL_LOCK;
        else if (idx >= 8'hE9 && idx <= 8'hED)  p = POL_LOCK;
        else if (idx == 8'hF3 || idx == 8'hF5 || idx == 8'hF7) p = POL_LOCK;
        else if (idx >= 8'hF9 && idx <= 8'hFB)  p = POL_LOCK;
        else if (idx >= 8'hFD)                  p = POL_LOCK;
        else if (idx == KEY_A_IDX || idx == KEY_B_IDX) p = POL_KEYED;
        return p;
    endfunction

    function automatic logic [7:0] key_of(input logic [7:0] idx);
        return (idx == KEY_A_IDX) ? KEY_A_VAL : KEY_B_VAL;
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] idx);
        logic [7:0] v;
        case (idx)
            8'hE0:   v = 8'h3C;
            8'hE2:   v = 8'h03;
            8'hE3:   v = 8'hFC;
            8'hE6:   v = 8'hDE;
            8'hE7:   v = KEY_A_VAL;
            8'hE8:   v = KEY_B_VAL;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cwp_index_reg.sv
module cwp_index_reg
    import cwp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    output logic [IDX_W-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= load_val;
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(idx)); // R7

endmodule

// File: rtl/cwp_write_gate.sv
module cwp_write_gate
    import cwp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              req,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] data,
    output logic              commit
);

    logic [7:0] idx8;
    wr_policy_e pol;

    always_comb begin
        idx8 = 8'(idx);
        pol  = policy_of(idx8);
        case (pol)
            POL_OPEN:  commit = req;
            POL_KEYED: commit = req && (data == key_of(idx8));
            default:   commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cwp_reg_file.sv
module cwp_reg_file
    import cwp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_val
);

    localparam int DEPTH = 1 << IDX_W;

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  we_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign we_vec[i] = commit && (wr_idx == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)            mem[i] <= reset_value(8'(i));
            else if (we_vec[i]) mem[i] <= wr_data;
        end
    end

    assign rd_val = mem[rd_idx];

    AST_ONE_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we_vec)); // R9
    AST_KEY_A_ONLY: assert property (@(posedge clk) disable iff (rst)
        (commit && 8'(wr_idx) == KEY_A_IDX) |-> (wr_data == KEY_A_VAL)); // R5
    AST_KEY_B_ONLY: assert property (@(posedge clk) disable iff (rst)
        (commit && 8'(wr_idx) == KEY_B_IDX) |-> (wr_data == KEY_B_VAL)); // R6
    AST_LOCK_LOW: assert property (@(posedge clk) disable iff (rst)
        commit |-> (8'(wr_idx) > 8'hDF)); // R4

endmodule

// File: rtl/cfg_window_port.sv
module cfg_window_port
    import cwp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        win_en,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);

    bus_req_t          req;
    logic [IDX_W-1:0]  cur_idx;
    logic              idx_load;
    logic              data_req;
    logic              commit;
    logic [BYTE_W-1:0] entry_val;
    logic [BYTE_W-1:0] rdata_q;

    always_comb begin
        req.wr   = bus_wr && win_en;
        req.rd   = bus_rd;
        req.hi   = bus_addr;
        req.data = bus_wdata;
        idx_load = req.wr && !req.hi;
        data_req = req.wr && req.hi;
    end

    cwp_index_reg #(.IDX_W(IDX_W)) u_idx (
        .clk      (clk),
        .rst      (rst),
        .load     (idx_load),
        .load_val (IDX_W'(req.data)),
        .idx      (cur_idx)
    );

    cwp_write_gate #(.IDX_W(IDX_W)) u_gate (
        .req    (data_req),
        .idx    (cur_idx),
        .data   (req.data),
        .commit (commit)
    );

    cwp_reg_file #(.IDX_W(IDX_W)) u_file (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .wr_idx  (cur_idx),
        .wr_data (req.data),
        .rd_idx  (cur_idx),
        .rd_val  (entry_val)
    );

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= FLOAT_VAL;
        else if (req.rd) rdata_q <= win_en ? entry_val : FLOAT_VAL;
    end

    assign bus_rdata = rdata_q;

    AST_FLOAT_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !win_en) |=> (bus_rdata == FLOAT_VAL)); // R7
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R2
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        (win_en && bus_wr && !bus_addr) |=> (cur_idx == IDX_W'($past(bus_wdata)))); // R2
    AST_NO_WR_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> !commit); // R7
    AST_IDX_NOT_DATA: assert property (@(posedge clk) disable iff (rst)
        (win_en && bus_wr && bus_addr) |=> $stable(cur_idx)); // R9

endmodule

// File: tb/sim_cfg_window_port.sv
module sim_cfg_window_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       win_en = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int total = 0;
    int bad = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    cfg_window_port u0 (
        .clk(clk), .rst(rst), .win_en(win_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic bit is_locked(input int i);
        return (i <= 'hDF) || i == 'hE4 || i == 'hE5 ||
               (i >= 'hE9 && i <= 'hED) || i == 'hF3 || i == 'hF5 ||
               i == 'hF7 || (i >= 'hF9 && i <= 'hFB) || i >= 'hFD;
    endfunction

    function automatic void model_write(input int i, input logic [7:0] d);
        if (is_locked(i)) return;
        if (i == 'hE7 && d != 8'hFE) return;
        if (i == 'hE8 && d != 8'hBE) return;
        model[i] = d;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check("R1 rdata after reset", bus_rdata, 8'hFF);
        win_en = 1'b1;
        bus_read(1'b1, v);
        check("R1 pointer reset selects entry 0", v, 8'h00);
        for (int i = 0; i < 256; i++) begin
            bus_write(1'b0, 8'(i));
            bus_read(1'b1, v);
            check($sformatf("R1 reset value of %h", i), v, model[i]);
        end
    endtask

    task automatic t_sweep;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) begin
            bus_write(1'b0, 8'(i));
            bus_write(1'b1, 8'h5A);
            model_write(i, 8'h5A);
            bus_read(1'b1, v);
            check($sformatf("R3 R4 sweep entry %h", i), v, model[i]);
        end
    endtask

    task automatic t_open_values;
        logic [7:0] v;
        bus_write(1'b0, 8'hF4);
        bus_write(1'b1, 8'hA5);
        model_write('hF4, 8'hA5);
        bus_read(1'b1, v);
        check("R3 open entry F4", v, 8'hA5);
        bus_write(1'b1, 8'h00);
        model_write('hF4, 8'h00);
        bus_read(1'b1, v);
        check("R3 open entry F4 second value", v, 8'h00);
        bus_read(1'b0, v);
        check("R8 read at offset 0 gives entry", v, 8'h00);
        bus_write(1'b0, 8'hE0);
        bus_read(1'b0, v);
        check("R8 read at offset 0 not pointer", v, model['hE0]);
    endtask

    task automatic t_keys;
        logic [7:0] v;
        bus_write(1'b0, 8'hE7);
        bus_write(1'b1, 8'h12);
        bus_read(1'b1, v);
        check("R5 wrong key dropped", v, 8'hFE);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, v);
        check("R5 near key dropped", v, 8'hFE);
        bus_write(1'b1, 8'hFE);
        bus_read(1'b1, v);
        check("R5 right key kept", v, 8'hFE);
        bus_write(1'b0, 8'hE8);
        bus_write(1'b1, 8'hFE);
        bus_read(1'b1, v);
        check("R6 other key dropped", v, 8'hBE);
        bus_write(1'b1, 8'hBE);
        bus_read(1'b1, v);
        check("R6 right key kept", v, 8'hBE);
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        bus_write(1'b0, 8'hE1);
        bus_write(1'b1, 8'h77);
        model_write('hE1, 8'h77);
        win_en = 1'b0;
        bus_read(1'b1, v);
        check("R7 disabled read floats", v, 8'hFF);
        bus_write(1'b1, 8'h99);
        bus_write(1'b0, 8'hE2);
        bus_read(1'b0, v);
        check("R7 disabled read offset 0 floats", v, 8'hFF);
        win_en = 1'b1;
        bus_read(1'b1, v);
        check("R7 pointer and entry untouched", v, 8'h77);
        @(negedge clk);
        check("R2 rdata holds without strobe", bus_rdata, 8'h77);
    endtask

    task automatic t_single_update;
        logic [7:0] v;
        bus_write(1'b0, 8'hEE);
        bus_write(1'b1, 8'hEF);
        model_write('hEE, 8'hEF);
        bus_read(1'b1, v);
        check("R9 data write leaves pointer", v, 8'hEF);
        bus_write(1'b0, 8'hEF);
        bus_read(1'b1, v);
        check("R9 neighbour untouched", v, model['hEF]);
        bus_write(1'b0, 8'hEE);
        bus_read(1'b1, v);
        check("R9 pointer write leaves entry", v, 8'hEF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        model['hE0] = 8'h3C; model['hE2] = 8'h03; model['hE3] = 8'hFC;
        model['hE6] = 8'hDE; model['hE7] = 8'hFE; model['hE8] = 8'hBE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sweep();
        t_open_values();
        t_keys();
        t_disabled();
        t_single_update();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule